// File: doc/BRIEF.md
# Modulated audio delay line

This block delays an 8-bit audio stream by a slowly swept amount, for use in a chorus or flanger. Each signed input sample arrives with a sample strobe. It is converted to offset binary and written into a 256-entry circular buffer. On a separate, independent output tick the block reads one buffer entry. That entry trails the newest sample by a delay offset, and the offset rises and falls as a slow triangle. The entry read becomes an 8-bit duty word for a downstream PWM or PDM stage. The duty word holds its value between ticks.

The write path does more than append. On every strobe it does four things. It stores the previously captured raw sample at the previous write slot. It captures the new sample. It overwrites the current slot with the mean of that slot's old contents and the new sample. Then it advances both pointers. The sweep is a two-state machine with the states SWP_UP and SWP_DOWN. A tick counter steps the offset once each time it wraps. The transition SWP_UP to SWP_DOWN is taken when a step lands on the top value, 2^AW-1. The transition SWP_DOWN to SWP_UP is taken when a step lands on 0. In every other case the machine stays in its current state.

Top module: `mod_delay_line`

## Requirements
- R1: After reset, `duty` is 128, `duty_valid` is 0, and every buffer entry reads as 128, so ticks before any sample give 128.
- R2: A signed input sample s is stored as s+128 modulo 256 (offset binary).
- R3: On a sample strobe, the raw value captured on the previous strobe is written to the previous write slot. The current slot becomes (old + new) >> 1, where new is the converted sample and old is the slot's contents after that first write. The previous-write pointer then takes the current write pointer, and the write pointer increments modulo 256.
- R4: Each tick increments a tick counter of TICK_W bits. The delay offset changes only on the tick where that counter wraps to 0, and then by exactly one.
- R5: The offset starts at 0 moving upward. The direction reverses when a step makes the offset 255 or 0, so the offset traces a triangle from 0 to 255 and back.
- R6: On a tick, the entry at address (previous-write pointer - offset) mod 256 is loaded into `duty`. The offset used is the one after that tick's step.
- R7: Between ticks `duty` does not change (zero-order hold).
- R8: When a strobe and a tick share a cycle, the write completes first. The read then uses the updated buffer, the updated previous-write pointer and the stepped offset.
- R9: `duty_valid` is high for exactly the one cycle after each tick and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| smp_data | input | 8 | Signed two's complement sample |
| tick | input | 1 | Output tick strobe |
| duty | output | 8 | Tapped duty word, offset binary |
| duty_valid | output | 1 | One-cycle pulse when `duty` is refreshed |

## Verification
The bench builds the design with a 2-bit tick counter, so that a whole triangle sweep fits in about 2000 ticks. It checks every tapped word through both reversals. If a design reversed one step late or early, or let the offset wrap past 255 or below 0, the tap would jump by about 255 slots and read wrong samples. If the write order were reversed, the current slot would keep the raw value instead of the mean, so the zero-offset taps would differ. Shared strobe-and-tick cycles catch a read that uses the stale previous-write pointer, which would be off by one slot. Ticks given before any sample expose a buffer that does not reset to mid-scale.

// File: rtl/mdl_pkg.sv
package mdl_pkg;
    typedef enum logic {
        SWP_UP   = 1'b0,
        SWP_DOWN = 1'b1
    } sweep_state_t;
endpackage

// File: rtl/mdl_wbuf.sv
module mdl_wbuf #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] last_nxt
);
    localparam int DEPTH = 1 << AW;
    localparam logic [DW-1:0] MID = DW'(1 << (DW - 1));

    logic [DW-1:0] mem     [DEPTH];
    logic [DW-1:0] mem_nxt [DEPTH];
    logic [AW-1:0] wp, last;
    logic [DW-1:0] cap, cap_nxt, old_eff, avg;
    logic [DW:0]   sum;

    always_comb begin
        cap_nxt  = smp_valid ? (smp_data + MID) : cap;
        old_eff  = (wp == last) ? cap : mem[wp];
        sum      = {1'b0, old_eff} + {1'b0, cap_nxt};
        avg      = sum[DW:1];
        last_nxt = smp_valid ? wp : last;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam logic [AW-1:0] IDX = AW'(g);
        always_comb begin
            mem_nxt[g] = mem[g];
            if (smp_valid) begin
                if (IDX == wp)
                    mem_nxt[g] = avg;
                else if (IDX == last)
                    mem_nxt[g] = cap;
            end
        end
        always_ff @(posedge clk) begin
            if (!rst_n) mem[g] <= MID;
            else        mem[g] <= mem_nxt[g];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp   <= '0;
            last <= '0;
            cap  <= MID;
        end else if (smp_valid) begin
            last <= wp;
            wp   <= wp + AW'(1);
            cap  <= cap_nxt;
        end
    end

    assign rd_data = mem_nxt[rd_addr];

    AST_WP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (wp == $past(wp) + AW'(1))); // R3
    AST_LAST_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (last == $past(wp))); // R3
    AST_WP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(wp)); // R3
endmodule

// File: rtl/mdl_sweep.sv
module mdl_sweep
    import mdl_pkg::*;
#(
    parameter int AW     = 8,
    parameter int TICK_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic [AW-1:0] off_nxt
);
    localparam logic [AW-1:0] TOP = '1;

    sweep_state_t      state_q, state_d;
    logic [TICK_W-1:0] cnt, cnt_d;
    logic [AW-1:0]     off;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SWP_UP;
            cnt     <= '0;
            off     <= '0;
        end else begin
            state_q <= state_d;
            cnt     <= cnt_d;
            off     <= off_nxt;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt;
        off_nxt = off;
        if (tick) begin
            cnt_d = cnt + TICK_W'(1);
            if (cnt_d == '0) begin
                unique case (state_q)
                    SWP_UP: begin
                        off_nxt = off + AW'(1);
                        if (off_nxt == TOP) state_d = SWP_DOWN;
                    end
                    SWP_DOWN: begin
                        off_nxt = off - AW'(1);
                        if (off_nxt == '0) state_d = SWP_UP;
                    end
                endcase
            end
        end
    end

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && (cnt == '1)) |=> $stable(off)); // R4
    AST_UP_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SWP_UP) |-> (off != TOP)); // R5
    AST_DOWN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SWP_DOWN) |-> (off != '0)); // R5
endmodule

// File: rtl/mdl_tap.sv
module mdl_tap #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [AW-1:0] last_nxt,
    input  logic [AW-1:0] off_nxt,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] duty,
    output logic          duty_valid
);
    localparam logic [DW-1:0] MID = DW'(1 << (DW - 1));

    assign rd_addr = last_nxt - off_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty       <= MID;
            duty_valid <= 1'b0;
        end else begin
            duty_valid <= tick;
            if (tick) duty <= rd_data;
        end
    end

    AST_ZOH: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(duty)); // R7
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> duty_valid); // R9
    AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !duty_valid); // R9
endmodule

// File: rtl/mod_delay_line.sv
module mod_delay_line #(
    parameter int DW     = 8,
    parameter int AW     = 8,
    parameter int TICK_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] smp_data,
    input  logic                 tick,
    output logic        [DW-1:0] duty,
    output logic                 duty_valid
);
    logic [AW-1:0] rd_addr, last_nxt, off_nxt;
    logic [DW-1:0] rd_data;

    mdl_wbuf #(.DW(DW), .AW(AW)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_data(smp_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .last_nxt(last_nxt)
    );

    mdl_sweep #(.AW(AW), .TICK_W(TICK_W)) u_sweep (
        .clk(clk), .rst_n(rst_n), .tick(tick), .off_nxt(off_nxt)
    );

    mdl_tap #(.DW(DW), .AW(AW)) u_tap (
        .clk(clk), .rst_n(rst_n), .tick(tick), .last_nxt(last_nxt),
        .off_nxt(off_nxt), .rd_addr(rd_addr), .rd_data(rd_data),
        .duty(duty), .duty_valid(duty_valid)
    );
endmodule

// File: tb/mod_delay_line_tb.sv
module mod_delay_line_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [7:0] smp_data = '0;
    logic tick = 1'b0;
    logic [7:0] duty;
    logic duty_valid;

    int checks = 0;
    int fails = 0;

    logic [7:0] qv[$];
    string qt[$];

    logic [7:0] mref [256];
    int m_wp, m_last, m_cap, m_cnt, m_off;
    bit m_up;
    logic [7:0] prev_duty;
    bit mon_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mod_delay_line #(.DW(8), .AW(8), .TICK_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .tick(tick), .duty(duty), .duty_valid(duty_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input bit s, input logic [7:0] d, input bit t, input string tag);
        string tg;
        bit stepped = 0, flipped = 0;
        @(negedge clk);
        smp_valid = s; smp_data = d; tick = t;
        if (s) begin
            mref[m_last] = 8'(m_cap);
            m_cap = (int'(d) + 128) & 255;
            mref[m_wp] = 8'((int'(mref[m_wp]) + m_cap) >> 1);
            m_last = m_wp;
            m_wp = (m_wp + 1) & 255;
        end
        if (t) begin
            m_cnt = (m_cnt + 1) % (1 << TW);
            if (m_cnt == 0) begin
                stepped = 1;
                m_off = m_up ? m_off + 1 : m_off - 1;
                if (m_off == 0 || m_off == 255) begin
                    m_up = !m_up;
                    flipped = 1;
                end
            end
            tg = tag;
            if (tg == "") begin
                if (flipped) tg = "R5";
                else if (stepped) tg = "R4";
                else if (s) tg = "R8";
                else tg = "R6";
            end
            qv.push_back(mref[(m_last - m_off) & 255]);
            qt.push_back(tg);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (duty_valid) begin
                if (qv.size() == 0) begin
                    check(0, "R9", 1, 0);
                end else begin
                    logic [7:0] e;
                    string tg;
                    e = qv.pop_front();
                    tg = qt.pop_front();
                    check(duty == e, tg, duty, e);
                end
            end else begin
                check(duty == prev_duty, "R7", duty, prev_duty);
            end
            prev_duty = duty;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog expired (R1..R9 not completed): actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mref[i] = 8'd128;
        m_wp = 0; m_last = 0; m_cap = 128; m_cnt = 0; m_off = 0; m_up = 1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(duty == 8'd128, "R1", duty, 128);
        check(duty_valid == 1'b0, "R1", duty_valid, 0);
        prev_duty = duty;
        mon_on = 1'b1;
        // R1: ticks before any sample read mid-scale
        for (int i = 0; i < 3; i++) drive(0, 8'h00, 1, "R1");
        // R2: one sample, then a tick on it
        drive(1, 8'h0A, 0, "");
        drive(0, 8'h00, 1, "R2");
        // R3: raw versus averaged slots
        drive(1, 8'hFA, 0, "");
        drive(1, 8'h80, 0, "");
        drive(0, 8'h00, 1, "R3");
        // R8: strobe and tick together
        drive(1, 8'h7F, 1, "R8");
        // ramp, tick every other cycle
        for (int i = 0; i < 600; i++) drive(1, 8'(i), (i % 2) == 1, "");
        // full triangle: both strobes every cycle
        for (int i = 0; i < 2200; i++) drive(1, 8'(i * 3), 1, "");
        // ticks only
        for (int i = 0; i < 300; i++) drive(0, 8'h00, 1, "R6");
        // samples with sparse ticks
        for (int i = 0; i < 200; i++) drive(1, 8'(255 - i), (i % 5) == 0, "");
        drive(0, 8'h00, 0, "");
        repeat (3) @(negedge clk);
        check(qv.size() == 0, "R9", qv.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule